// File: doc/BRIEF.md
# Sub-word Load/Store Lane Aligner

This block sits between a processor load/store port and a memory side that is organised in whole 32-bit words, such as a data cache or a word-wide bus. For a load it checks the alignment of the request and picks the addressed byte or halfword out of the word returned by memory, zero-extended. For a store it merges the new byte or halfword into the word already held, so that the memory side only ever writes whole words, and it reports which half of the cache line the written word lives in so that the line's dirty bookkeeping can be updated.

Alongside the data path it forms two addresses: the word-aligned lookup address presented to the cache, and the physical byte address used when the access bypasses the cache. Lane selection honours a big-endian input. An alignment-check enable decides whether misaligned requests fault or are silently served from the aligned word. The result of every request is registered and appears one cycle later with its status flags.

Top module: `lane_aligner`

## Requirements
- R1: Every request on `req_valid` produces exactly one response with `rsp_valid` high in the next cycle; fault, error, dirty flags, data and addresses of that response belong to that request. After reset `rsp_valid`, `rsp_fault`, `rsp_size_err`, both dirty flags, `rsp_data` and both addresses are 0; in a cycle after no request all flags are 0 and data and addresses keep their values.
- R2: `req_size` encodes 0 = byte, 1 = halfword, 2 = word. Code 3 raises `rsp_size_err` and never `rsp_fault`; `rsp_data`, `rsp_lookup_addr` and `rsp_bus_addr` keep their previous values and no dirty flag is set.
- R3: With `align_chk_en` high, a word request with address bits [1:0] not 00, or a halfword request with address bit 0 set, raises `rsp_fault`; the access does not proceed: data and both addresses keep their previous values and no dirty flag is set.
- R4: With `align_chk_en` low no alignment fault is raised; the lookup address is still word-aligned and the original low address bits still pick the lane.
- R5: A halfword load returns `(req_word >> off) & 0xFFFF` with `off = ((big_endian*2) XOR (addr & 2)) * 8`.
- R6: A byte load returns `(req_word >> off) & 0xFF` with `off = ((big_endian*3) XOR (addr & 3)) * 8`.
- R7: A byte or halfword store returns `req_word` with the lane at the R5/R6 offset cleared and replaced by the low bits of `req_wdata`; a word store returns `req_wdata` unchanged.
- R8: A completed store sets `rsp_dirty_lo` when the word index `addr[4:2]` (for an 8-word line) is below half the line's word count, and `rsp_dirty_hi` otherwise; a load sets neither.
- R9: `rsp_bus_addr` is `req_pbase` with bits [1:0] cleared, OR `addr & 3` for a byte, OR `addr & 2` for a halfword, and nothing for a word.
- R10: `rsp_lookup_addr` of every completed access is `req_addr` with bits [1:0] cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (0 byte, 1 halfword, 2 word, 3 invalid) |
| req_addr | input | 32 | Byte address of the access before alignment |
| req_pbase | input | 32 | Physical address of the word; low two bits ignored |
| req_word | input | 32 | Word read from memory (load) or currently held (store) |
| req_wdata | input | 32 | Store data, right-aligned |
| align_chk_en | input | 1 | Enables alignment faults |
| big_endian | input | 1 | Selects big-endian lane numbering |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 1 | Alignment fault |
| rsp_size_err | output | 1 | Invalid size code |
| rsp_data | output | 32 | Load result or merged store word |
| rsp_lookup_addr | output | 32 | Word-aligned lookup address |
| rsp_bus_addr | output | 32 | Physical byte address for uncached access |
| rsp_dirty_lo | output | 1 | Store touched the first half of the line |
| rsp_dirty_hi | output | 1 | Store touched the second half of the line |

## Verification
The hardest case to reach is a misaligned request served with the alignment check off, where the lane must come from the original low bits while the lookup address is cleared, combined with the big-endian flip; random addresses hit it only when all three inputs line up. The stimulus therefore draws the check enable, the endianness and all four low address bits uniformly, and adds directed requests at address offset 3 with the check off in both endiannesses. Held-value behaviour after faults and size errors is reached by placing a faulting request directly after a completed one with known data.

// File: rtl/lane_pkg.sv
package lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

endpackage

// File: rtl/lane_sel.sv
// Lane offset, lane mask and request legality from size and low address bits.
module lane_sel
    import lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]                 size,
    input  logic [$clog2(DATA_W/8)-1:0] addr_lo,
    input  logic                       big_endian,
    output logic [$clog2(DATA_W)-1:0]  shift,
    output logic [DATA_W-1:0]          lane_mask,
    output logic                       misaligned,
    output logic                       size_bad
);
    localparam int NB = DATA_W / 8;
    localparam int LW = $clog2(NB);
    localparam logic [LW-1:0] TOP_BYTE = LW'(NB - 1);
    localparam logic [LW-1:0] TOP_HALF = LW'(NB - 2);
    localparam logic [LW-1:0] HALF_CLR = ~LW'(1);

    logic [LW-1:0] lane_d;

    always_comb begin
        lane_d     = '0;
        lane_mask  = '1;
        misaligned = 1'b0;
        size_bad   = 1'b0;
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                lane_d    = (big_endian ? TOP_BYTE : '0) ^ addr_lo;
                lane_mask = DATA_W'(8'hFF) << {lane_d, 3'b000};
            end
            SZ_HALF: begin
                lane_d     = (big_endian ? TOP_HALF : '0) ^ (addr_lo & HALF_CLR);
                lane_mask  = DATA_W'(16'hFFFF) << {lane_d, 3'b000};
                misaligned = addr_lo[0];
            end
            SZ_WORD: begin
                lane_d     = '0;
                lane_mask  = '1;
                misaligned = (addr_lo != '0);
            end
            default: begin
                size_bad = 1'b1;
            end
        endcase
        shift = {lane_d, 3'b000};
    end

endmodule

// File: rtl/lane_extract.sv
// Pulls the addressed lane out of a memory word, zero-extended.
module lane_extract
    import lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         word,
    input  logic [$clog2(DATA_W)-1:0] shift,
    input  logic [1:0]                size,
    output logic [DATA_W-1:0]         result
);
    logic [DATA_W-1:0] keep_d;
    logic [DATA_W-1:0] shifted_d;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: keep_d = DATA_W'(8'hFF);
            SZ_HALF: keep_d = DATA_W'(16'hFFFF);
            default: keep_d = '1;
        endcase
        shifted_d = word >> shift;
        result    = shifted_d & keep_d;
    end

endmodule

// File: rtl/lane_merge.sv
// Replaces the addressed lane of the held word with new store data.
module lane_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         old_word,
    input  logic [DATA_W-1:0]         new_data,
    input  logic [$clog2(DATA_W)-1:0] shift,
    input  logic [DATA_W-1:0]         lane_mask,
    output logic [DATA_W-1:0]         merged
);
    localparam int NB = DATA_W / 8;

    logic [DATA_W-1:0] placed;

    assign placed = new_data << shift;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign merged[b*8 +: 8] = lane_mask[b*8] ? placed[b*8 +: 8]
                                                 : old_word[b*8 +: 8];
    end

endmodule

// File: rtl/lane_addr_form.sv
// Lookup address, uncached bus address and line-half selection.
module lane_addr_form
    import lane_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] pbase,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] lookup_addr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              first_half
);
    localparam int NB   = DATA_W / 8;
    localparam int LW   = $clog2(NB);
    localparam int IDXW = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
    localparam logic [IDXW:0] HALF_WORDS = (IDXW + 1)'(LINE_WORDS / 2);
    localparam logic [LW-1:0] HALF_CLR   = ~LW'(1);

    logic [LW-1:0]   sub_d;
    logic [IDXW-1:0] widx;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: sub_d = vaddr[LW-1:0];
            SZ_HALF: sub_d = vaddr[LW-1:0] & HALF_CLR;
            default: sub_d = '0;
        endcase
        lookup_addr = {vaddr[ADDR_W-1:LW], LW'(0)};
        bus_addr    = {pbase[ADDR_W-1:LW], sub_d};
        widx        = vaddr[LW +: IDXW];
        first_half  = ({1'b0, widx} < HALF_WORDS);
    end

endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
    import lane_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_pbase,
    input  logic [DATA_W-1:0] req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              align_chk_en,
    input  logic              big_endian,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_size_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] rsp_lookup_addr,
    output logic [ADDR_W-1:0] rsp_bus_addr,
    output logic              rsp_dirty_lo,
    output logic              rsp_dirty_hi
);
    localparam int NB  = DATA_W / 8;
    localparam int LW  = $clog2(NB);
    localparam int SHW = $clog2(DATA_W);

    typedef struct packed {
        logic              valid;
        logic              fault;
        logic              err;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] lookup;
        logic [ADDR_W-1:0] bus;
        logic              dirty_lo;
        logic              dirty_hi;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [SHW-1:0]    shift;
    logic [DATA_W-1:0] lane_mask;
    logic              misaligned;
    logic              size_bad;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] store_val;
    logic [ADDR_W-1:0] lookup_addr;
    logic [ADDR_W-1:0] bus_addr;
    logic              first_half;

    lane_sel #(.DATA_W(DATA_W)) u_sel (
        .size       (req_size),
        .addr_lo    (req_addr[LW-1:0]),
        .big_endian (big_endian),
        .shift      (shift),
        .lane_mask  (lane_mask),
        .misaligned (misaligned),
        .size_bad   (size_bad)
    );

    lane_extract #(.DATA_W(DATA_W)) u_extract (
        .word   (req_word),
        .shift  (shift),
        .size   (req_size),
        .result (load_val)
    );

    lane_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word  (req_word),
        .new_data  (req_wdata),
        .shift     (shift),
        .lane_mask (lane_mask),
        .merged    (store_val)
    );

    lane_addr_form #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_addr (
        .vaddr       (req_addr),
        .pbase       (req_pbase),
        .size        (req_size),
        .lookup_addr (lookup_addr),
        .bus_addr    (bus_addr),
        .first_half  (first_half)
    );

    always_comb begin
        rsp_d          = rsp_q;
        rsp_d.valid    = req_valid;
        rsp_d.fault    = 1'b0;
        rsp_d.err      = 1'b0;
        rsp_d.dirty_lo = 1'b0;
        rsp_d.dirty_hi = 1'b0;
        if (req_valid) begin
            if (size_bad) begin
                rsp_d.err = 1'b1;
            end else if (misaligned && align_chk_en) begin
                rsp_d.fault = 1'b1;
            end else begin
                rsp_d.data     = req_store ? store_val : load_val;
                rsp_d.lookup   = lookup_addr;
                rsp_d.bus      = bus_addr;
                rsp_d.dirty_lo = req_store && first_half;
                rsp_d.dirty_hi = req_store && !first_half;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid       = rsp_q.valid;
    assign rsp_fault       = rsp_q.fault;
    assign rsp_size_err    = rsp_q.err;
    assign rsp_data        = rsp_q.data;
    assign rsp_lookup_addr = rsp_q.lookup;
    assign rsp_bus_addr    = rsp_q.bus;
    assign rsp_dirty_lo    = rsp_q.dirty_lo;
    assign rsp_dirty_hi    = rsp_q.dirty_hi;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) else $error("response missing"); // R1

    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_fault || rsp_size_err || rsp_dirty_lo || rsp_dirty_hi))
        else $error("flag without response"); // R1

    AST_ERR_NOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_size_err |-> !rsp_fault) else $error("error and fault together"); // R2

    AST_ERR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd3) |=> $stable(rsp_data) && $stable(rsp_bus_addr))
        else $error("size error changed data"); // R2

    AST_FAULT_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> $stable(rsp_data) && $stable(rsp_lookup_addr) && !rsp_dirty_lo && !rsp_dirty_hi)
        else $error("faulted access proceeded"); // R3

    AST_NO_FAULT_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !align_chk_en) |=> !rsp_fault) else $error("fault with check off"); // R4

    AST_DIRTY_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_dirty_lo, rsp_dirty_hi}) <= 1) else $error("both halves dirty"); // R8

    AST_LOAD_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |=> !rsp_dirty_lo && !rsp_dirty_hi) else $error("load marked dirty"); // R8

    AST_LOOKUP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_lookup_addr[LW-1:0] == '0) else $error("lookup not aligned"); // R10

endmodule

// File: tb/sim_lane_aligner.sv
`timescale 1ns/1ps
module sim_lane_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_pbase = '0;
    logic [31:0] req_word = '0;
    logic [31:0] req_wdata = '0;
    logic        align_chk_en = 1'b0;
    logic        big_endian = 1'b0;
    logic        rsp_valid, rsp_fault, rsp_size_err, rsp_dirty_lo, rsp_dirty_hi;
    logic [31:0] rsp_data, rsp_lookup_addr, rsp_bus_addr;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_data = '0;
    logic [31:0] m_look = '0;
    logic [31:0] m_bus  = '0;

    always #2 clk = ~clk;

    lane_aligner u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_addr(req_addr), .req_pbase(req_pbase),
        .req_word(req_word), .req_wdata(req_wdata), .align_chk_en(align_chk_en),
        .big_endian(big_endian), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_size_err(rsp_size_err), .rsp_data(rsp_data),
        .rsp_lookup_addr(rsp_lookup_addr), .rsp_bus_addr(rsp_bus_addr),
        .rsp_dirty_lo(rsp_dirty_lo), .rsp_dirty_hi(rsp_dirty_hi)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_load(input logic [1:0] sz, input logic [31:0] a,
                                             input logic [31:0] w, input logic be);
        int off;
        if (sz == 2'd0) begin
            off = ((be ? 3 : 0) ^ int'(a & 3)) * 8;
            return (w >> off) & 32'hFF;
        end else if (sz == 2'd1) begin
            off = ((be ? 2 : 0) ^ int'(a & 2)) * 8;
            return (w >> off) & 32'hFFFF;
        end
        return w;
    endfunction

    function automatic logic [31:0] exp_store(input logic [1:0] sz, input logic [31:0] a,
                                              input logic [31:0] w, input logic [31:0] nd,
                                              input logic be);
        int off;
        logic [31:0] m;
        if (sz == 2'd0) begin
            off = ((be ? 3 : 0) ^ int'(a & 3)) * 8;
            m = 32'hFF << off;
            return (w & ~m) | ((nd & 32'hFF) << off);
        end else if (sz == 2'd1) begin
            off = ((be ? 2 : 0) ^ int'(a & 2)) * 8;
            m = 32'hFFFF << off;
            return (w & ~m) | ((nd & 32'hFFFF) << off);
        end
        return nd;
    endfunction

    // Drive one request at a falling edge, check its response at the next falling edge.
    task automatic run(input string req, input logic st, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] pb, input logic [31:0] w,
                       input logic [31:0] nd, input logic chk_en, input logic be);
        logic e_fault, e_err, e_lo, e_hi;
        e_err = (sz == 2'd3);
        e_fault = !e_err && chk_en && ((sz == 2'd2 && a[1:0] != 2'b00) || (sz == 2'd1 && a[0]));
        e_lo = 1'b0;
        e_hi = 1'b0;
        if (!e_err && !e_fault) begin
            m_data = st ? exp_store(sz, a, w, nd, be) : exp_load(sz, a, w, be);
            m_look = a & 32'hFFFF_FFFC;
            m_bus  = (pb & 32'hFFFF_FFFC) | (sz == 2'd0 ? (a & 3) : sz == 2'd1 ? (a & 2) : 32'd0);
            e_lo   = st && (a[4:2] < 3'd4);
            e_hi   = st && !(a[4:2] < 3'd4);
        end
        req_valid = 1'b1; req_store = st; req_size = sz; req_addr = a; req_pbase = pb;
        req_word = w; req_wdata = nd; align_chk_en = chk_en; big_endian = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "valid", 32'(rsp_valid), 32'd1);
        chk(e_err ? "R2" : "R3", "fault", 32'(rsp_fault), 32'(e_fault));
        chk("R2", "size_err", 32'(rsp_size_err), 32'(e_err));
        chk(st ? "R7" : (sz == 2'd0 ? "R6" : "R5"), "data", rsp_data, m_data);
        chk("R10", "lookup", rsp_lookup_addr, m_look);
        chk("R9", "bus", rsp_bus_addr, m_bus);
        chk("R8", "dirty_lo", 32'(rsp_dirty_lo), 32'(e_lo));
        chk("R8", "dirty_hi", 32'(rsp_dirty_hi), 32'(e_hi));
    endtask

    task automatic idle_check;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "idle valid", 32'(rsp_valid), 32'd0);
        chk("R1", "idle flags", {28'd0, rsp_fault, rsp_size_err, rsp_dirty_lo, rsp_dirty_hi}, 32'd0);
        chk("R1", "idle data held", rsp_data, m_data);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R1", "reset valid", 32'(rsp_valid), 32'd0);
        chk("R1", "reset data", rsp_data, 32'd0);
        chk("R1", "reset flags", {28'd0, rsp_fault, rsp_size_err, rsp_dirty_lo, rsp_dirty_hi}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Loads, both endiannesses
        run("R6", 0, 2'd0, 32'h1000_0001, 32'h8000_0000, 32'h4433_2211, 0, 1, 0); // 0x22
        run("R6", 0, 2'd0, 32'h1000_0001, 32'h8000_0000, 32'h4433_2211, 0, 1, 1); // 0x33
        run("R5", 0, 2'd1, 32'h1000_0002, 32'h8000_0000, 32'h4433_2211, 0, 1, 0); // 0x4433
        run("R5", 0, 2'd1, 32'h1000_0002, 32'h8000_0000, 32'h4433_2211, 0, 1, 1); // 0x2211
        // Alignment faults hold prior data
        run("R3", 0, 2'd2, 32'h1000_0002, 32'h8000_0000, 32'hDEAD_BEEF, 0, 1, 0);
        run("R3", 1, 2'd1, 32'h1000_0011, 32'h8000_0000, 32'hDEAD_BEEF, 32'h55, 1, 0);
        // Check disabled: low bits still select the lane
        run("R4", 0, 2'd2, 32'h1000_0003, 32'h8000_0000, 32'hCAFE_F00D, 0, 0, 0);
        run("R4", 0, 2'd1, 32'h1000_0003, 32'h8000_0000, 32'h4433_2211, 0, 0, 0);
        run("R4", 0, 2'd0, 32'h1000_0003, 32'h8000_0000, 32'h4433_2211, 0, 0, 1);
        // Invalid size
        run("R2", 1, 2'd3, 32'h1000_0000, 32'h8000_0000, 32'h1111_1111, 32'h2222_2222, 1, 0);
        // Stores and line-half boundary
        run("R7", 1, 2'd0, 32'h2000_000C, 32'h9000_0000, 32'hAABB_CCDD, 32'h0000_0077, 1, 0);
        run("R8", 1, 2'd0, 32'h2000_0010, 32'h9000_0000, 32'hAABB_CCDD, 32'h0000_0077, 1, 1);
        run("R7", 1, 2'd1, 32'h2000_001E, 32'h9000_0000, 32'hAABB_CCDD, 32'h0000_1234, 1, 1);
        run("R7", 1, 2'd2, 32'h2000_0000, 32'h9000_0000, 32'hAABB_CCDD, 32'h1357_9BDF, 1, 0);
        // Bus address with junk in physical low bits
        run("R9", 0, 2'd0, 32'h3000_0001, 32'h8000_0003, 32'h0102_0304, 0, 1, 0);
        run("R9", 0, 2'd1, 32'h3000_0003, 32'h8000_0003, 32'h0102_0304, 0, 0, 0);
        idle_check();

        for (int i = 0; i < 600; i++) begin
            logic [1:0] sz;
            sz = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
            run("R5", 1'($urandom), sz, $urandom, $urandom, $urandom, $urandom,
                1'($urandom), 1'($urandom));
            if (i % 50 == 0) idle_check();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule